// File: doc/BRIEF.md
# Analog PLL Register Window

This block is a 64 KiB register window on a 32-bit register bus. It holds the control area for the PLLs and power management of a clock subsystem. The window has three regions. The first is a bank of PLL configuration and status words. The second is a bank of power-management words. The third is a single read-only revision word. The revision word sits on top of the other regions and wins wherever it overlaps one of them.

Each word in both banks takes a 16-byte slot. The four aliases in a slot are plain write, set bits, clear bits and toggle bits. Software can therefore change single fields without a read-modify-write sequence.

At reset the PLL bank loads fixed configuration values. Every PLL control word then reports its lock flag as set, so firmware that polls for lock finds it at once. No real PLL or frequency logic sits behind the registers.

A request is one cycle with `reqValid` high. A read returns its data on `rdData` in the cycle after the request, and `rdData` holds that value until the next read.

Top module: `anapll_regmap`

## Requirements
- R1: After reset, the PLL bank reads with bit 31 (lock flag) set in every PLL control word, as follows. Slot 0 at 0x60 reads 0x80002042, 0x70 reads 0x8060302C, 0xB0 reads 0x80002000, 0xC0 reads 0xD2605A56, 0xD0 reads 0xD2525216, 0xE0 reads 0x80001FC0, 0xF0 reads 0x8001301B, 0x130 reads 0x8008201B and 0x170 reads 0x80000000. The fractional words read without a lock flag: 0x90 reads 0x06AAAC4D, 0xA0 reads 0x100003EC, 0x110 reads 0x05F5E100, 0x120 reads 0x2964619C, 0x150 reads 0x0000F699 and 0x160 reads 0x000F4240.
- R2: After reset, the spread-spectrum words (0x80, 0x100, 0x140) and all sixteen power-management words (0x200 to 0x2F0) read zero.
- R3: The revision word at 0x800 reads 0x00720010.
- R4: Writes to the revision word, through any value, leave its read value unchanged.
- R5: A write to slot offset +0x0 of a bank word replaces the whole word.
- R6: A write to slot offset +0x4 ORs the write data into the word.
- R7: A write to slot offset +0x8 clears the bits that are set in the write data.
- R8: A write to slot offset +0xC XORs the write data into the word.
- R9: A read of any of the four aliases of a slot returns the current word.
- R10: The power-management bank starts at 0x200 and has sixteen slots with the same aliasing. Its writes never change the PLL bank.
- R11: Reads of offsets that no region covers (for example 0x0, 0x180, 0x1F0, 0x804 and 0xFFFC) return zero, and writes to them change no register.
- R12: An access whose address bits [1:0] are not zero is misaligned. A misaligned write changes no register, and a misaligned read returns zero.
- R13: When a bank is placed so that it covers 0x800, the word at 0x800 still reads the revision value and cannot be written. The other aliases of that bank slot stay usable.
- R14: Read data appears on `rdData` in the cycle after the read request. It is zero after reset and holds its value through idle and write cycles until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request in this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte offset into the window |
| reqWdata | input | 32 | Write data |
| rdData | output | 32 | Registered read data |

## Verification
Reads of every PLL-bank slot after reset separate words that carry the lock flag from fractional and spread-spectrum words that must not carry it. Write data with distinct bit patterns goes through each of the four aliases. Each pattern leaves a different result, so an alias decoded to the wrong operation shows up, as does a slot index taken from the wrong address bits. Unmapped, misaligned and revision-word writes are each followed by reads of the words they could have corrupted. A second instance moves the power-management bank over 0x800, which tells the overlay priority apart from an ordinary bank hit. Idle and write cycles after a read confirm that `rdData` only changes when a read is issued.

// File: rtl/anapll_pkg.sv
package anapll_pkg;

  localparam int DATA_W     = 32;
  localparam int IDX_W      = 8;   // slot index width, banks up to 256 slots
  localparam int SLOT_SHIFT = 4;   // 16 bytes per word: four aliases
  localparam int LOCK_BIT   = 31;

  // encoding equals address bits [3:2] of the alias
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } bitOp_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ANA  = 2'd1,
    SRC_PMU  = 2'd2,
    SRC_REV  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic             anaWr;
    logic             pmuWr;
    logic             rdEn;
    rdSrc_e           rdSrc;
    bitOp_e           op;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;

  function automatic logic [DATA_W-1:0] pllBaseValue(input int slot);
    case (slot)
      0:       return 32'h0000_2042;
      1:       return 32'h0060_302C;
      3:       return 32'h06AA_AC4D;
      4:       return 32'h1000_03EC;
      5:       return 32'h0000_2000;
      6:       return 32'h5260_5A56;
      7:       return 32'h5252_5216;
      8:       return 32'h0000_1FC0;
      9:       return 32'h0001_301B;
      11:      return 32'h05F5_E100;
      12:      return 32'h2964_619C;
      13:      return 32'h0008_201B;
      15:      return 32'h0000_F699;
      16:      return 32'h000F_4240;
      default: return '0;
    endcase
  endfunction

  function automatic logic pllHasLock(input int slot);
    case (slot)
      0, 1, 5, 6, 7, 8, 9, 13, 17: return 1'b1;
      default:                     return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] anaResetValue(input int slot);
    logic [DATA_W-1:0] v;
    v = pllBaseValue(slot);
    if (pllHasLock(slot)) v[LOCK_BIT] = 1'b1;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] applyBitOp(input bitOp_e op,
                                                   input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] wr);
    case (op)
      OP_SET:  return cur | wr;
      OP_CLR:  return cur & ~wr;
      OP_TOG:  return cur ^ wr;
      default: return wr;
    endcase
  endfunction

endpackage

// File: rtl/anapll_ctrl.sv
module anapll_ctrl
  import anapll_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ANA_BASE = 32'h60,
  parameter int NUM_ANA  = 18,
  parameter int PMU_BASE = 32'h200,
  parameter int NUM_PMU  = 16,
  parameter int REV_ADDR = 32'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output regStrobe_t        strb
);

  localparam int SLOT_BYTES = 1 << SLOT_SHIFT;
  localparam int ANA_END    = ANA_BASE + NUM_ANA * SLOT_BYTES;
  localparam int PMU_END    = PMU_BASE + NUM_PMU * SLOT_BYTES;

  logic              aligned;
  logic              revHit;
  logic              pmuHit;
  logic              anaHit;
  logic [ADDR_W-1:0] anaOff;
  logic [ADDR_W-1:0] pmuOff;

  always_comb begin
    aligned = (reqAddr[1:0] == 2'b00);
    revHit  = aligned && (reqAddr == ADDR_W'(REV_ADDR));
    pmuHit  = aligned && (int'(reqAddr) >= PMU_BASE) && (int'(reqAddr) < PMU_END);
    anaHit  = aligned && (int'(reqAddr) >= ANA_BASE) && (int'(reqAddr) < ANA_END);
    anaOff  = reqAddr - ADDR_W'(ANA_BASE);
    pmuOff  = reqAddr - ADDR_W'(PMU_BASE);
  end

  // priority: revision overlay, then power bank, then PLL bank
  always_comb begin
    strb       = '0;
    strb.op    = bitOp_e'(reqAddr[3:2]);
    strb.rdSrc = SRC_NONE;
    if (revHit) begin
      strb.rdSrc = SRC_REV;
    end else if (pmuHit) begin
      strb.rdSrc = SRC_PMU;
      strb.idx   = IDX_W'(pmuOff >> SLOT_SHIFT);
    end else if (anaHit) begin
      strb.rdSrc = SRC_ANA;
      strb.idx   = IDX_W'(anaOff >> SLOT_SHIFT);
    end
    strb.rdEn  = reqValid && !reqWrite;
    strb.anaWr = reqValid && reqWrite && (strb.rdSrc == SRC_ANA);
    strb.pmuWr = reqValid && reqWrite && (strb.rdSrc == SRC_PMU);
  end

  // R12
  misaligned_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && (reqAddr[1:0] != 2'b00)) |-> !(strb.anaWr || strb.pmuWr));

  // R4
  rev_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && (reqAddr == ADDR_W'(REV_ADDR))) |-> !(strb.anaWr || strb.pmuWr));

endmodule

// File: rtl/anapll_dp.sv
module anapll_dp
  import anapll_pkg::*;
#(
  parameter int                NUM_ANA   = 18,
  parameter int                NUM_PMU   = 16,
  parameter logic [DATA_W-1:0] REV_VALUE = 32'h0072_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] anaRegs [NUM_ANA];
  logic [DATA_W-1:0] pmuRegs [NUM_PMU];
  logic [DATA_W-1:0] anaSel;
  logic [DATA_W-1:0] pmuSel;
  logic [DATA_W-1:0] rdNext;

  for (genvar g = 0; g < NUM_ANA; g++) begin : g_ana
    localparam logic [DATA_W-1:0] RST_VAL = anaResetValue(g);
    logic              hit;
    logic [DATA_W-1:0] q;
    assign hit = strb.anaWr && (strb.idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)      q <= RST_VAL;
      else if (hit) q <= applyBitOp(strb.op, q, wdata);
    end
    assign anaRegs[g] = q;

    // R6
    ana_set_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && strb.op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));

    if (pllHasLock(g)) begin : g_lock
      // R1
      lock_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> q[LOCK_BIT]);
    end
  end

  for (genvar g = 0; g < NUM_PMU; g++) begin : g_pmu
    logic              hit;
    logic [DATA_W-1:0] q;
    assign hit = strb.pmuWr && (strb.idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (hit) q <= applyBitOp(strb.op, q, wdata);
    end
    assign pmuRegs[g] = q;

    // R7
    pmu_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && strb.op == OP_CLR) |=> ((q & $past(wdata)) == '0));
  end

  always_comb begin
    anaSel = '0;
    for (int i = 0; i < NUM_ANA; i++)
      if (strb.idx == IDX_W'(i)) anaSel = anaRegs[i];
    pmuSel = '0;
    for (int i = 0; i < NUM_PMU; i++)
      if (strb.idx == IDX_W'(i)) pmuSel = pmuRegs[i];
    case (strb.rdSrc)
      SRC_ANA: rdNext = anaSel;
      SRC_PMU: rdNext = pmuSel;
      SRC_REV: rdNext = REV_VALUE;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  // R3
  rev_read_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.rdSrc == SRC_REV) |=> (rdData == REV_VALUE));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.rdSrc == SRC_NONE) |=> (rdData == '0));

  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |=> $stable(rdData));

endmodule

// File: rtl/anapll_regmap.sv
module anapll_regmap
  import anapll_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                ANA_BASE  = 32'h60,
  parameter int                NUM_ANA   = 18,
  parameter int                PMU_BASE  = 32'h200,
  parameter int                NUM_PMU   = 16,
  parameter int                REV_ADDR  = 32'h800,
  parameter logic [DATA_W-1:0] REV_VALUE = 32'h0072_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       rdData
);

  regStrobe_t strb;

  anapll_ctrl #(
    .ADDR_W  (ADDR_W),
    .ANA_BASE(ANA_BASE),
    .NUM_ANA (NUM_ANA),
    .PMU_BASE(PMU_BASE),
    .NUM_PMU (NUM_PMU),
    .REV_ADDR(REV_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .strb    (strb)
  );

  anapll_dp #(
    .NUM_ANA  (NUM_ANA),
    .NUM_PMU  (NUM_PMU),
    .REV_VALUE(REV_VALUE)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .wdata (reqWdata),
    .rdData(rdData)
  );

endmodule

// File: tb/anapll_regmap_bench.sv
`timescale 1ns/1ps
module anapll_regmap_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rdMain;
  logic [31:0] rdOvl;
  int          testCount = 0;
  int          failCount = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  anapll_regmap u_anapll_regmap (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdMain)
  );

  // power bank moved over the revision word (R13)
  anapll_regmap #(.PMU_BASE(32'h7C0), .NUM_PMU(8)) u_anapll_regmap_ovl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdOvl)
  );

  localparam logic [31:0] REV = 32'h0072_0010;

  function automatic logic [31:0] expAna(input int i);
    case (i)
      0:  return 32'h8000_2042;
      1:  return 32'h8060_302C;
      3:  return 32'h06AA_AC4D;
      4:  return 32'h1000_03EC;
      5:  return 32'h8000_2000;
      6:  return 32'hD260_5A56;
      7:  return 32'hD252_5216;
      8:  return 32'h8000_1FC0;
      9:  return 32'h8001_301B;
      11: return 32'h05F5_E100;
      12: return 32'h2964_619C;
      13: return 32'h8008_201B;
      15: return 32'h0000_F699;
      16: return 32'h000F_4240;
      17: return 32'h8000_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] m, output logic [31:0] o);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    m = rdMain; o = rdOvl;
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] m, o;
    check("R14 rdData zero after reset", rdMain, 32'h0);
    for (int i = 0; i < 18; i++) begin
      busRead(16'(32'h60 + i * 16), m, o);
      if (i == 2 || i == 10 || i == 14) check("R2 spread word reset", m, 32'h0);
      else check("R1 PLL bank reset", m, expAna(i));
    end
    for (int i = 0; i < 16; i++) begin
      busRead(16'(32'h200 + i * 16), m, o);
      check("R2 power word reset", m, 32'h0);
    end
    busRead(16'h0800, m, o);
    check("R3 revision value", m, REV);
  endtask

  task automatic testPlainWrite();
    logic [31:0] m, o;
    busWrite(16'h0060, 32'h1234_5678);
    busRead(16'h0060, m, o);
    check("R5 plain write", m, 32'h1234_5678);
    busRead(16'h0064, m, o);
    check("R9 read set alias", m, 32'h1234_5678);
    busRead(16'h0068, m, o);
    check("R9 read clear alias", m, 32'h1234_5678);
    busRead(16'h006C, m, o);
    check("R9 read toggle alias", m, 32'h1234_5678);
  endtask

  task automatic testSet();
    logic [31:0] m, o;
    busWrite(16'h0074, 32'h0000_00F0);
    busRead(16'h0070, m, o);
    check("R6 set alias", m, 32'h8060_30FC);
  endtask

  task automatic testClear();
    logic [31:0] m, o;
    busWrite(16'h00B8, 32'h8000_0000);
    busRead(16'h00B0, m, o);
    check("R7 clear alias", m, 32'h0000_2000);
  endtask

  task automatic testToggle();
    logic [31:0] m, o;
    busWrite(16'h00EC, 32'hFFFF_0000);
    busRead(16'h00E0, m, o);
    check("R8 toggle alias", m, 32'h7FFF_1FC0);
    busWrite(16'h00EC, 32'hFFFF_0000);
    busRead(16'h00E0, m, o);
    check("R8 toggle back", m, 32'h8000_1FC0);
  endtask

  task automatic testPower();
    logic [31:0] m, o;
    busWrite(16'h0200, 32'hA5A5_0000);
    busRead(16'h0200, m, o);
    check("R10 power plain write", m, 32'hA5A5_0000);
    busWrite(16'h0208, 32'hFF00_0000);
    busRead(16'h0204, m, o);
    check("R10 power clear", m, 32'h00A5_0000);
    busWrite(16'h0214, 32'h0000_0003);
    busRead(16'h0210, m, o);
    check("R10 power set", m, 32'h0000_0003);
    busWrite(16'h02FC, 32'h0000_0001);
    busRead(16'h02F0, m, o);
    check("R10 power last slot toggle", m, 32'h0000_0001);
    busRead(16'h0060, m, o);
    check("R10 PLL bank untouched", m, 32'h1234_5678);
  endtask

  task automatic testRevision();
    logic [31:0] m, o;
    busWrite(16'h0800, 32'h0000_0000);
    busWrite(16'h0800, 32'hFFFF_FFFF);
    busRead(16'h0800, m, o);
    check("R4 revision write ignored", m, REV);
  endtask

  task automatic testUnmapped();
    logic [31:0] m, o;
    busWrite(16'h0000, 32'hFFFF_FFFF);
    busWrite(16'h0180, 32'hFFFF_FFFF);
    busWrite(16'h01F0, 32'hFFFF_FFFF);
    busWrite(16'hFFFC, 32'hFFFF_FFFF);
    busRead(16'h0000, m, o);
    check("R11 unmapped 0x0", m, 32'h0);
    busRead(16'h0180, m, o);
    check("R11 unmapped 0x180", m, 32'h0);
    busRead(16'h01F0, m, o);
    check("R11 unmapped 0x1F0", m, 32'h0);
    busRead(16'hFFFC, m, o);
    check("R11 unmapped 0xFFFC", m, 32'h0);
    busRead(16'h0170, m, o);
    check("R11 last PLL word kept", m, 32'h8000_0000);
    busRead(16'h0200, m, o);
    check("R11 first power word kept", m, 32'h00A5_0000);
  endtask

  task automatic testMisaligned();
    logic [31:0] m, o;
    busWrite(16'h0162, 32'h0000_0000);
    busWrite(16'h0201, 32'hFFFF_FFFF);
    busRead(16'h0160, m, o);
    check("R12 misaligned write dropped", m, 32'h000F_4240);
    busRead(16'h0200, m, o);
    check("R12 misaligned power write dropped", m, 32'h00A5_0000);
    busRead(16'h0162, m, o);
    check("R12 misaligned read zero", m, 32'h0);
  endtask

  task automatic testOverlay();
    logic [31:0] m, o;
    busRead(16'h0800, m, o);
    check("R13 overlay read", o, REV);
    busWrite(16'h0800, 32'hFFFF_FFFF);
    busRead(16'h0808, m, o);
    check("R13 slot untouched by overlay write", o, 32'h0);
    busWrite(16'h0804, 32'h0000_0005);
    busRead(16'h0808, m, o);
    check("R13 other aliases usable", o, 32'h0000_0005);
    check("R11 0x808 unmapped in default map", m, 32'h0);
    busRead(16'h0800, m, o);
    check("R13 overlay still wins", o, REV);
    busRead(16'h0804, m, o);
    check("R11 0x804 unmapped in default map", m, 32'h0);
  endtask

  task automatic testTiming();
    logic [31:0] m, o;
    busRead(16'h0060, m, o);
    check("R14 data next cycle", m, 32'h1234_5678);
    repeat (3) @(negedge clk);
    check("R14 hold while idle", rdMain, 32'h1234_5678);
    busWrite(16'h0060, 32'hCAFE_0000);
    check("R14 hold through write", rdMain, 32'h1234_5678);
    busRead(16'h0060, m, o);
    check("R14 new data after read", m, 32'hCAFE_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    testReset();
    testPlainWrite();
    testSet();
    testClear();
    testToggle();
    testPower();
    testRevision();
    testUnmapped();
    testMisaligned();
    testOverlay();
    testTiming();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule